// File: doc/BRIEF.md
# Clock Pulse Count Guard

This block sits beside the serial command decoder of a small serial-access nonvolatile array. It protects the array from transfers that a noisy clock line has damaged. A spurious clock edge moves every later address and data bit by one position. The shift register cannot detect this, because the shifted content still looks like a legal frame. The guard therefore counts serial clock rising edges. Counting starts at the start bit and ends at the falling edge of the select line. A programming command may start its self-timed cycle only when that count equals the frame length exactly. The frame length depends on the command and on the selected array width.

All inputs are one-cycle strobes or levels in the system clock domain. They come from the edge detectors and the decoder that surround the block: a select level, a select-fall strobe, a serial-clock-rise strobe, a start-bit strobe, the decoded command class and the width select. The only output is a single-cycle execute pulse. Read commands and write-enable/disable commands are not checked against the count; they only need a frame that began with a start bit. All ports are plain control pins, with no stream handshake and no back-pressure.

Top module: `clk_pulse_guard`

## Requirements
- R1: While reset is held and in the first cycle after its release, `exec_go` is low.
- R2: The start-bit strobe counts as pulse 1. Each later `sclk_rise` strobe adds one pulse while `cs_level` is high.
- R3: A write command (class 3) executes only with exactly 18 pulses at x8 width (`org_x16`=0) or exactly 25 pulses at x16 width (`org_x16`=1).
- R4: Single erase (class 4) and erase-all (class 5) execute only with exactly 10 pulses at x8 width or exactly 9 pulses at x16 width.
- R5: Write-all (class 6) executes only with exactly 18 pulses at x8 width or exactly 25 pulses at x16 width.
- R6: A checked command whose count differs from its expected length gives no `exec_go` pulse.
- R7: Read (class 1) and write-enable/disable (class 2) ignore the count. They execute at the select fall whenever the frame began with a start bit.
- R8: The counter saturates at 2^CNT_W-1 (31 by default) and never wraps. A 50-pulse write frame is therefore rejected.
- R9: A new start-bit strobe while select is high restarts the count at 1.
- R10: A low `cs_level` clears the count. A frame with no start bit gives no `exec_go`, whatever its class.
- R11: `exec_go` is a one-cycle pulse. It is raised only in the cycle after a `cs_fall` strobe.
- R12: Classes 0 and 7 are idle or reserved codes and never execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_level | input | 1 | Synchronised select level; high while a frame is open |
| cs_fall | input | 1 | One-cycle strobe marking the select falling edge |
| sclk_rise | input | 1 | One-cycle strobe for each serial clock rising edge |
| start_det | input | 1 | Start-bit strobe, given in place of that edge's `sclk_rise` |
| instr_cls | input | 3 | Decoded command class, valid at `cs_fall` (codes in R3 to R7, R12) |
| org_x16 | input | 1 | Width select: 1 selects x16 words, 0 selects x8 bytes |
| exec_go | output | 1 | Qualified execute pulse |

## Verification
The count is held only inside the block. A wrong internal count therefore shows up only when a frame closes. It appears as a missing or extra `exec_go` pulse in the single cycle after `cs_fall`. Off-by-one errors are exposed by driving every checked class at both widths with the exact length and with one pulse fewer and one more. A counter that wraps is exposed by a 50-pulse write. With five bits, a wrapping counter reads 18 and falsely matches the x8 write length. The restart and clear rules are checked by opening a frame twice, and by closing a frame that never had a start bit.

// File: rtl/ccg_pkg.sv
package ccg_pkg;
  typedef enum logic [2:0] {
    CLS_IDLE  = 3'd0,
    CLS_READ  = 3'd1,
    CLS_WEN   = 3'd2,
    CLS_WRITE = 3'd3,
    CLS_ERASE = 3'd4,
    CLS_ERAL  = 3'd5,
    CLS_WRAL  = 3'd6,
    CLS_RSVD  = 3'd7
  } ccg_cls_e;

  // commands that start a self-timed program cycle
  function automatic logic is_checked(ccg_cls_e c);
    return (c == CLS_WRITE) || (c == CLS_ERASE) || (c == CLS_ERAL) || (c == CLS_WRAL);
  endfunction

  // commands that skip the length check
  function automatic logic is_bypass(ccg_cls_e c);
    return (c == CLS_READ) || (c == CLS_WEN);
  endfunction

  // frames that carry a data field after the address
  function automatic logic has_data(ccg_cls_e c);
    return (c == CLS_WRITE) || (c == CLS_WRAL);
  endfunction
endpackage

// File: rtl/ccg_pulse_ctr.sv
module ccg_pulse_ctr #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_level,
  input  logic             start_det,
  input  logic             sclk_rise,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic running;
  assign running = (cnt != '0) && (cnt != CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (!cs_level)            cnt <= '0;
    else if (start_det)            cnt <= CNT_ONE;
    else if (sclk_rise && running) cnt <= cnt + CNT_ONE;
  end

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && cs_level && !start_det) |=> (cnt == CNT_MAX));
  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && cs_level) |=> (cnt == CNT_ONE));
  // R10
  clear_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_level |=> (cnt == '0));
  // R2
  no_spont_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_level && !start_det && !sclk_rise) |=> $stable(cnt));
endmodule

// File: rtl/ccg_len_table.sv
module ccg_len_table
  import ccg_pkg::*;
#(
  parameter int CNT_W    = 5,
  parameter int OPC_BITS = 2,
  parameter int ADDR_X8  = 7,
  parameter int ADDR_X16 = 6,
  parameter int DATA_X8  = 8,
  parameter int DATA_X16 = 16
) (
  input  ccg_cls_e         cls,
  input  logic             org_x16,
  output logic [CNT_W-1:0] exp_len,
  output logic             checked,
  output logic             bypass
);
  logic [CNT_W-1:0] len_short [2];
  logic [CNT_W-1:0] len_long  [2];

  for (genvar o = 0; o < 2; o++) begin : g_org
    localparam int AW = (o == 1) ? ADDR_X16 : ADDR_X8;
    localparam int DW = (o == 1) ? DATA_X16 : DATA_X8;
    assign len_short[o] = CNT_W'(1 + OPC_BITS + AW);
    assign len_long[o]  = CNT_W'(1 + OPC_BITS + AW + DW);
  end

  always_comb begin
    if (!is_checked(cls)) exp_len = '0;
    else if (has_data(cls)) exp_len = len_long[org_x16];
    else exp_len = len_short[org_x16];
  end

  assign checked = is_checked(cls);
  assign bypass  = is_bypass(cls);
endmodule

// File: rtl/clk_pulse_guard.sv
module clk_pulse_guard
  import ccg_pkg::*;
#(
  parameter int CNT_W    = 5,
  parameter int OPC_BITS = 2,
  parameter int ADDR_X8  = 7,
  parameter int ADDR_X16 = 6,
  parameter int DATA_X8  = 8,
  parameter int DATA_X16 = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_level,
  input  logic       cs_fall,
  input  logic       sclk_rise,
  input  logic       start_det,
  input  logic [2:0] instr_cls,
  input  logic       org_x16,
  output logic       exec_go
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] exp_len;
  logic             checked, bypass;
  logic             started, len_ok, go_d;
  ccg_cls_e         cls;

  assign cls = ccg_cls_e'(instr_cls);

  ccg_pulse_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .cs_level(cs_level),
    .start_det(start_det), .sclk_rise(sclk_rise), .cnt(cnt)
  );

  ccg_len_table #(
    .CNT_W(CNT_W), .OPC_BITS(OPC_BITS), .ADDR_X8(ADDR_X8),
    .ADDR_X16(ADDR_X16), .DATA_X8(DATA_X8), .DATA_X16(DATA_X16)
  ) u_len (
    .cls(cls), .org_x16(org_x16), .exp_len(exp_len),
    .checked(checked), .bypass(bypass)
  );

  // count before the clear that the low select applies on this edge
  assign started = (cnt != '0);
  assign len_ok  = checked ? (cnt == exp_len) : bypass;
  assign go_d    = cs_fall && started && len_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exec_go <= 1'b0;
    else        exec_go <= go_d;
  end

  // R11
  exec_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go |-> $past(cs_fall));
  // R6
  exact_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_go && $past(checked)) |-> ($past(cnt) == $past(exp_len)));
  // R12
  idle_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go |-> ($past(checked) || $past(bypass)));
  // R10
  need_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go |-> ($past(cnt) != '0));
endmodule

// File: tb/sim_clk_pulse_guard.sv
module sim_clk_pulse_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_level = 1'b0, cs_fall = 1'b0, sclk_rise = 1'b0, start_det = 1'b0;
  logic [2:0] instr_cls = 3'd0;
  logic org_x16 = 1'b0;
  logic exec_go;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  clk_pulse_guard u0 (
    .clk(clk), .rst_n(rst_n), .cs_level(cs_level), .cs_fall(cs_fall),
    .sclk_rise(sclk_rise), .start_det(start_det), .instr_cls(instr_cls),
    .org_x16(org_x16), .exec_go(exec_go)
  );

  function automatic int frame_len(input int cls, input bit x16);
    int aw = x16 ? 6 : 7;
    int dw = x16 ? 16 : 8;
    if (cls == 3 || cls == 6) return 3 + aw + dw;
    if (cls == 4 || cls == 5) return 3 + aw;
    return 0;
  endfunction

  task automatic check(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: exec_go actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sclk_rise = 1'b1;
      @(negedge clk) sclk_rise = 1'b0;
    end
  endtask

  task automatic open_frame(input int cls, input bit x16);
    @(negedge clk) cs_level = 1'b1; instr_cls = 3'(cls); org_x16 = x16;
    @(negedge clk) start_det = 1'b1;
    @(negedge clk) start_det = 1'b0;
  endtask

  task automatic close_and_check(input bit exp, input string req);
    @(negedge clk) cs_level = 1'b0; cs_fall = 1'b1;
    @(negedge clk) cs_fall = 1'b0;
    check(exec_go, exp, req);
    @(negedge clk);
    check(exec_go, 1'b0, "R11 single pulse");
  endtask

  // n counts the start bit as pulse 1
  task automatic run_frame(input int cls, input bit x16, input int n,
                           input bit exp, input string req);
    open_frame(cls, x16);
    pulses(n - 1);
    close_and_check(exp, req);
  endtask

  task automatic test_reset();
    check(exec_go, 1'b0, "R1 in reset");
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check(exec_go, 1'b0, "R1 after release");
  endtask

  task automatic test_len(input int cls, input bit x16, input string req);
    int l = frame_len(cls, x16);
    run_frame(cls, x16, l,     1'b1, {req, " exact"});
    run_frame(cls, x16, l - 1, 1'b0, {req, " R6 short"});
    run_frame(cls, x16, l + 1, 1'b0, {req, " R6 long"});
  endtask

  task automatic test_bypass();
    run_frame(1, 1'b0, 7, 1'b1, "R7 read");
    run_frame(2, 1'b1, 12, 1'b1, "R7 enable");
  endtask

  task automatic test_idle();
    run_frame(0, 1'b0, 18, 1'b0, "R12 idle class");
    run_frame(7, 1'b1, 25, 1'b0, "R12 reserved class");
  endtask

  task automatic test_saturate();
    run_frame(3, 1'b0, 50, 1'b0, "R8 50 pulses");
    run_frame(3, 1'b0, 18, 1'b1, "R8 follow-up frame");
  endtask

  task automatic test_restart();
    open_frame(3, 1'b0);
    pulses(6);
    @(negedge clk) start_det = 1'b1;
    @(negedge clk) start_det = 1'b0;
    pulses(17);
    close_and_check(1'b1, "R9 restart then 18");
  endtask

  task automatic test_no_start();
    @(negedge clk) cs_level = 1'b0; instr_cls = 3'd1;
    pulses(4);
    @(negedge clk) cs_level = 1'b1;
    pulses(17);
    close_and_check(1'b0, "R10 no start read");
    @(negedge clk) cs_level = 1'b1; instr_cls = 3'd3; org_x16 = 1'b0;
    pulses(18);
    close_and_check(1'b0, "R2 R10 no start write");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    test_len(3, 1'b0, "R3 write x8");
    test_len(3, 1'b1, "R3 write x16");
    test_len(4, 1'b0, "R4 erase x8");
    test_len(4, 1'b1, "R4 erase x16");
    test_len(5, 1'b0, "R4 erase-all x8");
    test_len(5, 1'b1, "R4 erase-all x16");
    test_len(6, 1'b0, "R5 write-all x8");
    test_len(6, 1'b1, "R5 write-all x16");
    test_bypass();
    test_idle();
    test_saturate();
    test_restart();
    test_no_start();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule